// File: doc/BRIEF.md
# CAN Node Error Counters and Fault Confinement State

This block keeps the error bookkeeping of one CAN FD controller node. The protocol engine sends single-cycle requests to raise an error counter by one or by eight, or to lower it by one. A mode input says whether the node is currently transmitting or receiving, and that input picks which of the two 9-bit directional counters the request changes. Next to these, two 16-bit tallies count error events. One counts errors seen while sampling in the nominal bit-rate phase. The other counts errors seen while sampling in the data phase.

From the two directional counters the block derives the node's confinement state: error-active, error-passive or bus-off. The passive threshold and the warning limit are 8-bit values that software can write. A warning flag and a one-cycle pulse on every entry into or exit from error-passive are provided for the surrounding controller. Software can also load any subset of the four counters in a single cycle through a select mask and a 9-bit value.

Top module: `fault_conf_ctr`

## Requirements
- R1: After active-low reset, all four counters read zero, the state is error-active (code 0), and the passive threshold and warning limit are 127 and 63.
- R2: A raise or lower request changes only the TX counter when `is_transmitter` is 1, and only the RX counter when it is 0.
- R3: Lowering a counter that is already at zero leaves it at zero.
- R4: Each raise request (by one or by eight) adds exactly one to a single tally. The tally is `nom_tally` when `sample_kind` is 0 (nominal) and `dat_tally` when it is 1 (data), 2 (secondary) or 3. Lower requests leave both tallies unchanged.
- R5: Bit 0 of `sw_load_sel` loads `sw_load_val` into the TX counter, bit 1 into the RX counter, bit 2 into `nom_tally` and bit 3 into `dat_tally`, zero-extended for the tallies. Any combination of bits may be set in the same cycle.
- R6: For any counter whose select bit is set, the load takes priority over a hardware request in the same cycle. Counters whose select bit is clear still follow the request.
- R7: `node_state` is 2 (bus-off) when TX or RX is above 255. Otherwise it is 1 (error-passive) when either is above the passive threshold. Otherwise it is 0 (error-active).
- R8: A write strobe (`passive_wr` or `warn_wr`) stores its 8-bit value, and the new threshold governs the outputs from the next cycle.
- R9: A counter change caused by a request appears on the outputs in the clock cycle after the request.
- R10: Raises saturate at the counter maximum (511 for TX and RX, 65535 for the tallies) instead of wrapping.
- R11: `warn_flag` is 1 while TX or RX is at or above the warning limit.
- R12: `passive_toggle` is 1 for exactly the cycle in which the state has just entered or left error-passive.
- R13: When several request pulses coincide, raise-by-eight wins over raise-by-one, which wins over lower-by-one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bump_one | input | 1 | Raise the selected directional counter by one |
| bump_eight | input | 1 | Raise the selected directional counter by eight |
| drop_one | input | 1 | Lower the selected directional counter by one |
| is_transmitter | input | 1 | 1 = node transmits (TX counter), 0 = node receives (RX counter) |
| sample_kind | input | 2 | 0 nominal, 1 data, 2 secondary sampling |
| sw_load_sel | input | 4 | Load mask: bit0 TX, bit1 RX, bit2 nominal tally, bit3 data tally |
| sw_load_val | input | 9 | Value loaded into the selected counters |
| passive_wr | input | 1 | Write strobe for the passive threshold |
| passive_val | input | 8 | New passive threshold |
| warn_wr | input | 1 | Write strobe for the warning limit |
| warn_val | input | 8 | New warning limit |
| tx_cnt | output | 9 | Transmit error counter |
| rx_cnt | output | 9 | Receive error counter |
| nom_tally | output | 16 | Errors counted in the nominal phase |
| dat_tally | output | 16 | Errors counted in the data phase |
| node_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| warn_flag | output | 1 | A directional counter is at or above the warning limit |
| passive_toggle | output | 1 | One-cycle pulse on entering or leaving error-passive |

## Verification
Long runs of raise-by-one requests in transmit mode walk the TX counter through the warning limit, the passive threshold, the bus-off bound and saturation, while the sample kind rotates through all four codes. This separates the two tallies and the state thresholds from one another. Raise-by-eight runs in receive mode check routing by mode and saturation with the large step. Long lower-by-one runs check the floor at zero. Every one of the sixteen load masks is applied together with a raise request, which shows per-counter load priority. Coinciding pulses and threshold rewrites at a fixed count separate the request arbitration and the threshold registers from the counter logic.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    localparam logic [1:0] SMP_NOMINAL   = 2'd0;
    localparam logic [1:0] SMP_DATA      = 2'd1;
    localparam logic [1:0] SMP_SECONDARY = 2'd2;

    localparam int unsigned LOAD_TX  = 0;
    localparam int unsigned LOAD_RX  = 1;
    localparam int unsigned LOAD_NOM = 2;
    localparam int unsigned LOAD_DAT = 3;

endpackage

// File: rtl/fcc_err_ctr.sv
module fcc_err_ctr #(
    parameter int W        = 9,
    parameter int BIG_STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         up_one,
    input  logic         up_big,
    input  logic         down_one,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX  = '1;
    localparam logic [W-1:0] CNT_ONE  = W'(1);
    localparam logic [W:0]   STEP_BIG = (W+1)'(BIG_STEP);
    localparam logic [W:0]   STEP_ONE = (W+1)'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [W:0] sum_big_d, sum_one_d;

    always_comb begin
        sum_big_d = {1'b0, st_q.cnt} + STEP_BIG;
        sum_one_d = {1'b0, st_q.cnt} + STEP_ONE;
        st_d      = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (en) begin
            if (up_big) begin
                st_d.cnt = sum_big_d[W] ? CNT_MAX : sum_big_d[W-1:0];
            end else if (up_one) begin
                st_d.cnt = sum_one_d[W] ? CNT_MAX : sum_one_d[W-1:0];
            end else if (down_one && (st_q.cnt != '0)) begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));  // R6
    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && down_one && !up_one && !up_big && cnt_q == '0) |=> (cnt_q == '0));  // R3
    AST_INC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && (up_one || up_big) && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));  // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(cnt_q));  // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && up_one && !up_big && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));  // R9

endmodule

// File: rtl/fcc_phase_ctr.sv
module fcc_phase_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tally_state_t;

    tally_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (bump && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && bump && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));  // R4
    AST_TALLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !bump) |=> $stable(cnt_q));  // R4
    AST_TALLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));  // R10

endmodule

// File: rtl/fcc_state_eval.sv
module fcc_state_eval
    import fcc_pkg::*;
#(
    parameter int               CTR_W       = 9,
    parameter int               THR_W       = 8,
    parameter logic [THR_W-1:0] PASSIVE_RST = 8'h7F,
    parameter logic [THR_W-1:0] WARN_RST    = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTR_W-1:0] tx_cnt,
    input  logic [CTR_W-1:0] rx_cnt,
    input  logic             passive_wr,
    input  logic [THR_W-1:0] passive_val,
    input  logic             warn_wr,
    input  logic [THR_W-1:0] warn_val,
    output logic [1:0]       node_state,
    output logic             warn_flag,
    output logic             passive_toggle
);
    localparam logic [CTR_W-1:0] BUSOFF_LIM = CTR_W'((1 << THR_W) - 1);

    typedef struct packed {
        logic [THR_W-1:0] passive_thr;
        logic [THR_W-1:0] warn_thr;
        logic             was_passive;
    } eval_state_t;

    eval_state_t st_d, st_q;
    fc_state_e   state_now;
    logic [CTR_W-1:0] pthr_ext, wthr_ext;

    always_comb begin
        pthr_ext = CTR_W'(st_q.passive_thr);
        wthr_ext = CTR_W'(st_q.warn_thr);
        if ((tx_cnt > BUSOFF_LIM) || (rx_cnt > BUSOFF_LIM))      state_now = FC_BUSOFF;
        else if ((tx_cnt > pthr_ext) || (rx_cnt > pthr_ext))     state_now = FC_PASSIVE;
        else                                                     state_now = FC_ACTIVE;

        st_d             = st_q;
        st_d.was_passive = (state_now == FC_PASSIVE);
        if (passive_wr) st_d.passive_thr = passive_val;
        if (warn_wr)    st_d.warn_thr    = warn_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.passive_thr <= PASSIVE_RST;
            st_q.warn_thr    <= WARN_RST;
            st_q.was_passive <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign node_state     = state_now;
    assign warn_flag      = (tx_cnt >= wthr_ext) || (rx_cnt >= wthr_ext);
    assign passive_toggle = (state_now == FC_PASSIVE) != st_q.was_passive;

    AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        passive_wr |=> (st_q.passive_thr == $past(passive_val)));  // R8
    AST_WARN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        warn_wr |=> (st_q.warn_thr == $past(warn_val)));  // R8
    AST_TOGGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        passive_toggle |-> ((node_state == FC_PASSIVE) != $past(node_state == FC_PASSIVE)));  // R12
    AST_BUSOFF_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt > BUSOFF_LIM) |-> (node_state == FC_BUSOFF));  // R7

endmodule

// File: rtl/fault_conf_ctr.sv
module fault_conf_ctr
    import fcc_pkg::*;
#(
    parameter int               CTR_W       = 9,
    parameter int               TALLY_W     = 16,
    parameter int               THR_W       = 8,
    parameter int               BIG_STEP    = 8,
    parameter logic [THR_W-1:0] PASSIVE_RST = 8'h7F,
    parameter logic [THR_W-1:0] WARN_RST    = 8'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bump_one,
    input  logic               bump_eight,
    input  logic               drop_one,
    input  logic               is_transmitter,
    input  logic [1:0]         sample_kind,
    input  logic [3:0]         sw_load_sel,
    input  logic [CTR_W-1:0]   sw_load_val,
    input  logic               passive_wr,
    input  logic [THR_W-1:0]   passive_val,
    input  logic               warn_wr,
    input  logic [THR_W-1:0]   warn_val,
    output logic [CTR_W-1:0]   tx_cnt,
    output logic [CTR_W-1:0]   rx_cnt,
    output logic [TALLY_W-1:0] nom_tally,
    output logic [TALLY_W-1:0] dat_tally,
    output logic [1:0]         node_state,
    output logic               warn_flag,
    output logic               passive_toggle
);
    localparam int NUM_DIR   = 2;
    localparam int NUM_PHASE = 2;
    localparam int PAD_W     = TALLY_W - CTR_W;

    typedef struct packed {
        logic up_big;
        logic up_one;
        logic down;
        logic any_up;
        logic nominal;
    } req_t;

    req_t req_d;
    logic [CTR_W-1:0]   dir_cnt   [NUM_DIR];
    logic [TALLY_W-1:0] phase_cnt [NUM_PHASE];
    logic [TALLY_W-1:0] tally_load_val;

    always_comb begin
        req_d.up_big  = bump_eight;
        req_d.up_one  = bump_one && !bump_eight;
        req_d.down    = drop_one && !bump_one && !bump_eight;
        req_d.any_up  = bump_one || bump_eight;
        req_d.nominal = (sample_kind == SMP_NOMINAL);
        tally_load_val = {{PAD_W{1'b0}}, sw_load_val};
    end

    for (genvar gi = 0; gi < NUM_DIR; gi++) begin : g_dir
        fcc_err_ctr #(
            .W        (CTR_W),
            .BIG_STEP (BIG_STEP)
        ) u_dir (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       ((gi == 0) ? is_transmitter : !is_transmitter),
            .up_one   (req_d.up_one),
            .up_big   (req_d.up_big),
            .down_one (req_d.down),
            .load     (sw_load_sel[LOAD_TX + gi]),
            .load_val (sw_load_val),
            .cnt_q    (dir_cnt[gi])
        );
    end

    for (genvar gp = 0; gp < NUM_PHASE; gp++) begin : g_phase
        fcc_phase_ctr #(
            .W (TALLY_W)
        ) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .bump     (req_d.any_up && ((gp == 0) ? req_d.nominal : !req_d.nominal)),
            .load     (sw_load_sel[LOAD_NOM + gp]),
            .load_val (tally_load_val),
            .cnt_q    (phase_cnt[gp])
        );
    end

    assign tx_cnt    = dir_cnt[0];
    assign rx_cnt    = dir_cnt[1];
    assign nom_tally = phase_cnt[0];
    assign dat_tally = phase_cnt[1];

    fcc_state_eval #(
        .CTR_W       (CTR_W),
        .THR_W       (THR_W),
        .PASSIVE_RST (PASSIVE_RST),
        .WARN_RST    (WARN_RST)
    ) u_eval (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_cnt         (tx_cnt),
        .rx_cnt         (rx_cnt),
        .passive_wr     (passive_wr),
        .passive_val    (passive_val),
        .warn_wr        (warn_wr),
        .warn_val       (warn_val),
        .node_state     (node_state),
        .warn_flag      (warn_flag),
        .passive_toggle (passive_toggle)
    );

    AST_ROUTE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (is_transmitter && !sw_load_sel[LOAD_RX]) |=> $stable(rx_cnt));  // R2
    AST_ROUTE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_transmitter && !sw_load_sel[LOAD_TX]) |=> $stable(tx_cnt));  // R2
    AST_DROP_NO_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!bump_one && !bump_eight && sw_load_sel[LOAD_DAT:LOAD_NOM] == 2'b00)
        |=> ($stable(nom_tally) && $stable(dat_tally)));  // R4
    AST_BIG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_eight && is_transmitter && !sw_load_sel[LOAD_TX] && tx_cnt == '0)
        |=> (tx_cnt == CTR_W'(BIG_STEP)));  // R13

endmodule

// File: tb/fault_conf_ctr_bench.sv
module fault_conf_ctr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bump_one = 0, bump_eight = 0, drop_one = 0, is_transmitter = 1;
    logic [1:0]  sample_kind = 0;
    logic [3:0]  sw_load_sel = 0;
    logic [8:0]  sw_load_val = 0;
    logic        passive_wr = 0, warn_wr = 0;
    logic [7:0]  passive_val = 0, warn_val = 0;
    logic [8:0]  tx_cnt, rx_cnt;
    logic [15:0] nom_tally, dat_tally;
    logic [1:0]  node_state;
    logic        warn_flag, passive_toggle;

    int checks = 0;
    int failures = 0;
    int mtx = 0, mrx = 0, mnom = 0, mdat = 0, mpass = 127, mwarn = 63;
    int mstate = 0, mtog = 0;

    always #5 clk = ~clk;

    fault_conf_ctr u_fault_conf_ctr (
        .clk, .rst_n, .bump_one, .bump_eight, .drop_one, .is_transmitter,
        .sample_kind, .sw_load_sel, .sw_load_val, .passive_wr, .passive_val,
        .warn_wr, .warn_val, .tx_cnt, .rx_cnt, .nom_tally, .dat_tally,
        .node_state, .warn_flag, .passive_toggle
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "tx_cnt", int'(tx_cnt), mtx);
        chk(tag, "rx_cnt", int'(rx_cnt), mrx);
        chk("R4", "nom_tally", int'(nom_tally), mnom);
        chk("R4", "dat_tally", int'(dat_tally), mdat);
        chk("R7", "node_state", int'(node_state), mstate);
        chk("R11", "warn_flag", int'(warn_flag), ((mtx >= mwarn) || (mrx >= mwarn)) ? 1 : 0);
        chk("R12", "passive_toggle", int'(passive_toggle), mtog);
    endtask

    function automatic int dir_next(input int cur, input bit en, input bit e8, input bit o1, input bit d1);
        if (!en) return cur;
        if (e8) return (cur + 8 > 511) ? 511 : cur + 8;
        if (o1) return (cur + 1 > 511) ? 511 : cur + 1;
        if (d1) return (cur > 0) ? cur - 1 : 0;
        return cur;
    endfunction

    // One request cycle: drive at a falling edge, check at the next one.
    task automatic apply(input bit e8, input bit o1, input bit d1, input bit txm,
                         input int kind, input int sel, input int val,
                         input bit pw, input int pv, input bit ww, input int wv,
                         input string tag);
        bit old_pass;
        bit inc;
        bump_eight = e8; bump_one = o1; drop_one = d1; is_transmitter = txm;
        sample_kind = 2'(kind); sw_load_sel = 4'(sel); sw_load_val = 9'(val);
        passive_wr = pw; passive_val = 8'(pv); warn_wr = ww; warn_val = 8'(wv);
        old_pass = (mstate == 1);
        inc = e8 || o1;
        mtx = sel[0] ? val : dir_next(mtx, txm, e8, o1, d1);
        mrx = sel[1] ? val : dir_next(mrx, !txm, e8, o1, d1);
        if (sel[2]) mnom = val; else if (inc && kind == 0 && mnom < 65535) mnom++;
        if (sel[3]) mdat = val; else if (inc && kind != 0 && mdat < 65535) mdat++;
        if (pw) mpass = pv;
        if (ww) mwarn = wv;
        if (mtx > 255 || mrx > 255) mstate = 2;
        else if (mtx > mpass || mrx > mpass) mstate = 1;
        else mstate = 0;
        mtog = ((mstate == 1) != old_pass) ? 1 : 0;
        @(negedge clk);
        bump_eight = 0; bump_one = 0; drop_one = 0; sw_load_sel = 0;
        passive_wr = 0; warn_wr = 0;
        compare_all(tag);
    endtask

    task automatic load_ctr(input int sel, input int val, input string tag);
        apply(0, 0, 0, is_transmitter, int'(sample_kind), sel, val, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        compare_all("R1");

        // R1: reset thresholds seen through the outputs
        load_ctr(1, 62, "R1");
        load_ctr(1, 63, "R1");
        chk("R1", "warn at 63", int'(warn_flag), 1);
        load_ctr(1, 127, "R1");
        chk("R1", "active at 127", int'(node_state), 0);
        load_ctr(1, 128, "R1");
        chk("R1", "passive at 128", int'(node_state), 1);
        load_ctr(15, 0, "R5");

        // R2, R9, R10: transmitter raise-by-one sweep, rotating sample kinds
        for (int i = 0; i < 520; i++)
            apply(0, 1, 0, 1, i % 4, 0, 0, 0, 0, 0, 0, (i == 0) ? "R9" : "R2");
        chk("R10", "tx saturated", int'(tx_cnt), 511);
        chk("R7", "bus-off", int'(node_state), 2);

        // R3: lower below zero
        for (int i = 0; i < 515; i++)
            apply(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
        chk("R3", "tx floor", int'(tx_cnt), 0);

        // R2, R10: receiver raise-by-eight sweep
        for (int i = 0; i < 70; i++)
            apply(1, 0, 0, 0, i % 3, 0, 0, 0, 0, 0, 0, "R2");
        chk("R10", "rx saturated by eight", int'(rx_cnt), 511);
        for (int i = 0; i < 5; i++)
            apply(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R2");

        // R5, R6: all load masks together with a raise request
        for (int m = 0; m < 16; m++)
            apply(0, 1, 0, m % 2, m % 3, m, (m * 37 + 3) % 512, 0, 0, 0, 0, (m % 2) ? "R6" : "R5");

        // R13: coinciding pulses
        load_ctr(15, 0, "R5");
        apply(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R13");
        apply(0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R13");
        apply(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R13");
        chk("R13", "tx after arbitration", int'(tx_cnt), 8);

        // R8: threshold rewrites at a fixed count
        apply(0, 0, 0, 1, 0, 0, 0, 1, 7, 1, 9, "R8");
        chk("R8", "passive after thr write", int'(node_state), 1);
        chk("R8", "warn below new limit", int'(warn_flag), 0);
        apply(0, 0, 0, 1, 0, 0, 0, 1, 8, 1, 8, "R8");
        chk("R8", "active at equal thr", int'(node_state), 0);
        chk("R12", "toggle on leaving", int'(passive_toggle), 1);
        apply(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R12");

        // R7: bus-off bound on RX and passive just below it
        apply(0, 0, 0, 0, 0, 0, 0, 1, 254, 0, 0, "R8");
        load_ctr(2, 255, "R7");
        chk("R7", "passive at 255", int'(node_state), 1);
        load_ctr(2, 256, "R7");
        chk("R7", "bus-off at 256", int'(node_state), 2);

        finish_run();
    end
endmodule